// File: doc/BRIEF.md
# Four-Lane Idle-Column Rate Matcher

This block is the elastic buffer between a recovered receive clock and the local core clock on a four-lane link that uses 8b/10b coding. Each lane has already been decoded to a 9-bit symbol. The write side stores one column, meaning all four lanes taken together, on every recovered-clock edge. The read side delivers one column on every local-clock edge. The two clocks have the same nominal rate but come from independent sources, so the buffer fill drifts slowly.

To absorb that drift, the matcher adds or removes whole idle columns. An idle column is one in which every lane carries the /R/ control code. The block never touches a single symbol, so the lanes stay aligned with each other. All decisions are made in the read domain from the fill level seen there. The write pointer reaches the read domain, and the read pointer reaches the write domain, as Gray code through two-flop synchronizers. Output starts once the buffer has filled to its nominal level. After that the matcher holds the fill inside a band around that level, which covers an offset of 100 ppm with a wide margin.

Top module: `colRateMatcher`

## Requirements
- R1: A column is 36 bits wide. Lane n occupies bits [9n+8:9n]. Within a lane, bit 8 is the control flag and bits 7:0 are the data. The /R/ symbol is 9'h11C. A column counts as idle only when all four lanes equal 9'h11C.
- R2: Every column that is not idle reaches `rdCol` unchanged and in write order. This includes a column that mixes /R/ with other symbols. No such column is lost, duplicated or reordered.
- R3: The buffer holds 16 columns and never holds more than that.
- R4: During reset, `rdValid`, `insPulse` and `delPulse` are low. After reset, `rdValid` stays low until the read side sees a fill of at least 8 columns.
- R5: When the fill seen by the read side is above 10 and the oldest stored column is idle, that column is discarded. The following column is output in the same cycle, and `delPulse` is high for that one read cycle.
- R6: When an idle column is output while the read-side fill is below 6, the next read cycle outputs one extra idle column without consuming stored data. `insPulse` is high for that one cycle and never for two cycles in a row.
- R7: With equal write and read clock rates, the matcher neither inserts nor deletes.
- R8: When the read clock runs faster than the write clock, the matcher inserts idle columns and deletes none.
- R9: Once output has started, and while the clock offset stays within the tolerated range, `rdValid` stays high every read cycle. `insPulse` and `delPulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Recovered (write) clock |
| wrRstN | input | 1 | Active-low reset, write domain |
| wrCol | input | 36 | Incoming four-lane column, stored every wrClk edge |
| rdClk | input | 1 | Local (read) clock |
| rdRstN | input | 1 | Active-low reset, read domain |
| rdCol | output | 36 | Outgoing four-lane column |
| rdValid | output | 1 | rdCol carries a column this cycle |
| insPulse | output | 1 | One-cycle strobe: an idle column was inserted |
| delPulse | output | 1 | One-cycle strobe: an idle column was deleted |

## Verification
The stream is a seeded random mix of idle columns, columns that mix /R/ with other symbols, and arbitrary columns. It also contains directed bursts of mixed-only and idle-only columns. This stream runs with equal clocks, then with the read clock 1% fast, then with it 1% slow. The equal-rate run separates a correct fill band from thresholds that fire with no drift. The fast run must show insertions only, and the slow run must show deletions. Throughout, the non-idle columns are compared in order against a queue, so a dropped, repeated or damaged column is caught wherever compensation happens. Every insertion is checked to produce an idle column that directly follows an idle column.

// File: rtl/rmPkg.sv
package rmPkg;

  localparam int SYM_W = 9;
  localparam logic [SYM_W-1:0] IDLE_SYM = 9'h11C;

  // read-side strobes from control to datapath
  typedef struct packed {
    logic take1;    // output head column, advance by one
    logic take2;    // skip idle head, output next column, advance by two
    logic padIdle;  // output an extra idle column, no advance
  } rdStrobe_t;

endpackage

// File: rtl/rmDatapath.sv
module rmDatapath
  import rmPkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 4
) (
  input  logic                   wrClk,
  input  logic                   wrRstN,
  input  logic [LANES*SYM_W-1:0] wrCol,
  input  logic                   rdClk,
  input  logic                   rdRstN,
  input  rdStrobe_t              strobe,
  output logic [AW:0]            rdFill,
  output logic                   headIdle,
  output logic [LANES*SYM_W-1:0] rdCol,
  output logic                   rdValid
);

  localparam int COL_W = LANES * SYM_W;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [COL_W-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdGrayS1, rdGrayS2, rdBinW;
  logic          wrFull;

  assign rdBinW = toBin(rdGrayS2);
  assign wrFull = (wrBin - rdBinW) == DEPTH_V;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (!wrFull) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrRstN && !wrFull) mem[wrBin[AW-1:0]] <= wrCol;
  end

  // R3: the pointer that crosses domains changes by one bit per write
  p_gray_step_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // ---------------- read domain ----------------
  logic [PW-1:0]    rdBin, rdGray, wrGrayS1, wrGrayS2;
  logic [AW-1:0]    nextAddr;
  logic [COL_W-1:0] headCol, nextCol;
  logic [LANES-1:0] laneIdle;

  assign rdFill   = toBin(wrGrayS2) - rdBin;
  assign nextAddr = rdBin[AW-1:0] + 1'b1;
  assign headCol  = mem[rdBin[AW-1:0]];
  assign nextCol  = mem[nextAddr];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneIdle[l] = headCol[l*SYM_W +: SYM_W] == IDLE_SYM;
  end
  assign headIdle = (&laneIdle) && (rdFill != '0);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
      rdCol    <= '0;
      rdValid  <= 1'b0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      rdValid  <= strobe.take1 | strobe.take2 | strobe.padIdle;
      if (strobe.take2) begin
        rdCol  <= nextCol;
        rdBin  <= rdBin + PW'(2);
        rdGray <= toGray(rdBin + PW'(2));
      end else if (strobe.take1) begin
        rdCol  <= headCol;
        rdBin  <= rdBin + PW'(1);
        rdGray <= toGray(rdBin + PW'(1));
      end else if (strobe.padIdle) begin
        rdCol  <= {LANES{IDLE_SYM}};
      end
    end
  end

  // R3: the read side never sees more columns than the buffer holds
  p_no_overflow_r3: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdFill <= DEPTH_V);

endmodule

// File: rtl/rmControl.sv
module rmControl
  import rmPkg::*;
#(
  parameter int AW        = 4,
  parameter int NOMINAL   = 8,
  parameter int HIGH_MARK = 10,
  parameter int LOW_MARK  = 6
) (
  input  logic      rdClk,
  input  logic      rdRstN,
  input  logic [AW:0] rdFill,
  input  logic      headIdle,
  output rdStrobe_t strobe,
  output logic      insPulse,
  output logic      delPulse
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] NOM_V  = PW'(NOMINAL);
  localparam logic [PW-1:0] HIGH_V = PW'(HIGH_MARK);
  localparam logic [PW-1:0] LOW_V  = PW'(LOW_MARK);

  logic running, insPend;

  always_comb begin
    strobe = '0;
    if (running) begin
      if (insPend)                              strobe.padIdle = 1'b1;
      else if (rdFill == '0)                    strobe = '0;
      else if (headIdle && rdFill > HIGH_V)     strobe.take2 = 1'b1;
      else                                      strobe.take1 = 1'b1;
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      running  <= 1'b0;
      insPend  <= 1'b0;
      insPulse <= 1'b0;
      delPulse <= 1'b0;
    end else begin
      if (!running && rdFill >= NOM_V) running <= 1'b1;
      insPend  <= strobe.take1 && headIdle && (rdFill < LOW_V);
      insPulse <= strobe.padIdle;
      delPulse <= strobe.take2;
    end
  end

  // R6: an inserted column is a single column
  p_ins_single_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    insPulse |=> !insPulse);

  // R9: insertion and deletion never coincide
  p_pulse_excl_r9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !(insPulse && delPulse));

endmodule

// File: rtl/colRateMatcher.sv
module colRateMatcher
  import rmPkg::*;
#(
  parameter int LANES     = 4,
  parameter int AW        = 4,
  parameter int NOMINAL   = 8,
  parameter int HIGH_MARK = 10,
  parameter int LOW_MARK  = 6
) (
  input  logic                   wrClk,
  input  logic                   wrRstN,
  input  logic [LANES*SYM_W-1:0] wrCol,
  input  logic                   rdClk,
  input  logic                   rdRstN,
  output logic [LANES*SYM_W-1:0] rdCol,
  output logic                   rdValid,
  output logic                   insPulse,
  output logic                   delPulse
);

  localparam logic [LANES*SYM_W-1:0] IDLE_COL = {LANES{IDLE_SYM}};

  rdStrobe_t   strobe;
  logic [AW:0] rdFill;
  logic        headIdle;

  rmDatapath #(.LANES(LANES), .AW(AW)) u_data (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrCol(wrCol),
    .rdClk(rdClk), .rdRstN(rdRstN), .strobe(strobe),
    .rdFill(rdFill), .headIdle(headIdle),
    .rdCol(rdCol), .rdValid(rdValid)
  );

  rmControl #(.AW(AW), .NOMINAL(NOMINAL), .HIGH_MARK(HIGH_MARK),
              .LOW_MARK(LOW_MARK)) u_ctrl (
    .rdClk(rdClk), .rdRstN(rdRstN), .rdFill(rdFill), .headIdle(headIdle),
    .strobe(strobe), .insPulse(insPulse), .delPulse(delPulse)
  );

  // R6: an insertion emits an idle column right behind an idle column
  p_ins_idle_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    insPulse |-> (rdValid && rdCol == IDLE_COL && $past(rdCol) == IDLE_COL));

  // R5: a deletion still delivers a column in the same cycle
  p_del_valid_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    delPulse |-> rdValid);

endmodule

// File: tb/test_colRateMatcher.sv
`timescale 1ns/1ps
module test_colRateMatcher;

  localparam logic [8:0]  IDLE = 9'h11C;
  localparam logic [35:0] IDLE_COL = {4{IDLE}};
  localparam int PHASE_LEN = 15000;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic [35:0] wrCol = IDLE_COL;
  logic [35:0] rdCol;
  logic rdValid, insPulse, delPulse;

  realtime rdHalf = 10.0;
  int phase = 0;
  int nChecks = 0, nFails = 0;
  int insCnt[3], delCnt[3];
  int wrCount = 0, underflows = 0;
  bit started = 0, finished = 0;
  logic [35:0] expQ[$];
  logic [35:0] prevCol = '0;

  colRateMatcher i_colRateMatcher (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrCol(wrCol),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdCol(rdCol), .rdValid(rdValid),
    .insPulse(insPulse), .delPulse(delPulse)
  );

  always #10 wrClk = ~wrClk;
  initial begin
    #3;
    forever #(rdHalf) rdClk = ~rdClk;
  end

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  function automatic logic [35:0] genCol();
    logic [35:0] c;
    int r;
    r = $urandom % 10;
    if (r < 4) return IDLE_COL;
    for (int l = 0; l < 4; l++) c[l*9 +: 9] = 9'($urandom % 512);
    if (r < 6) begin
      for (int l = 1; l < 4; l++) if ($urandom % 2 == 1) c[l*9 +: 9] = IDLE;
      c[8:0] = {1'b0, 8'($urandom)};
    end
    return c;
  endfunction

  task automatic pushCol(input logic [35:0] c);
    @(negedge wrClk);
    wrCol = c;
    wrCount++;
    if (c != IDLE_COL) expQ.push_back(c);
  endtask

  // read-side monitor
  always @(negedge rdClk) begin
    if (!rdRstN) begin
      chk(!rdValid && !insPulse && !delPulse, "R4 reset outputs",
          $sformatf("%b%b%b", rdValid, insPulse, delPulse), "000");
    end else if (!finished) begin
      if (rdValid && !started) begin
        started = 1;
        chk(wrCount >= 8, "R4 start after nominal fill",
            $sformatf("%0d", wrCount), ">=8");
      end
      if (started && !rdValid) underflows++;
      if (insPulse) begin
        insCnt[phase]++;
        chk(rdCol == IDLE_COL && prevCol == IDLE_COL, "R1 R6 inserted idle column",
            $sformatf("%h/%h", prevCol, rdCol), $sformatf("%h/%h", IDLE_COL, IDLE_COL));
      end
      if (delPulse) delCnt[phase]++;
      if (insPulse && delPulse)
        chk(0, "R9 exclusive strobes", "both", "one");
      if (rdValid && rdCol != IDLE_COL) begin
        if (expQ.size() == 0)
          chk(0, "R2 column order", $sformatf("%h", rdCol), "nothing");
        else begin
          logic [35:0] e;
          e = expQ.pop_front();
          chk(rdCol == e, "R2 column order", $sformatf("%h", rdCol), $sformatf("%h", e));
        end
      end
      if (rdValid) prevCol = rdCol;
    end
  end

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #2_500_000;
    chk(0, "watchdog", "timeout", "done");
    finish();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge wrClk);
    @(negedge wrClk);
    wrRstN = 1;
    rdRstN = 1;
    // phase 0: equal rates, with directed bursts
    phase = 0; rdHalf = 10.0;
    for (int i = 0; i < PHASE_LEN; i++) begin
      if (i >= 5000 && i < 5040) begin
        logic [35:0] m;
        m = genCol();
        m[9 +: 9] = IDLE;            // mixed column holding /R/ lanes
        m[8:0] = {1'b1, 8'h3C};      // lane 0 carries another control code
        pushCol(m);
      end else if (i >= 6000 && i < 6040) pushCol(IDLE_COL);
      else pushCol(genCol());
    end
    // phase 1: read clock 1% fast
    phase = 1; rdHalf = 9.9;
    for (int i = 0; i < PHASE_LEN; i++) pushCol(genCol());
    // phase 2: read clock 1% slow
    phase = 2; rdHalf = 10.1;
    for (int i = 0; i < PHASE_LEN; i++) pushCol(genCol());
    for (int i = 0; i < 300; i++) pushCol(IDLE_COL);
    #100;
    chk(insCnt[0] == 0 && delCnt[0] == 0, "R7 equal rates no change",
        $sformatf("ins %0d del %0d", insCnt[0], delCnt[0]), "ins 0 del 0");
    chk(insCnt[1] > 0, "R8 R6 fast read inserts", $sformatf("%0d", insCnt[1]), ">0");
    chk(delCnt[1] == 0, "R8 fast read no deletion", $sformatf("%0d", delCnt[1]), "0");
    chk(delCnt[2] > 0, "R5 slow read deletes", $sformatf("%0d", delCnt[2]), ">0");
    chk(underflows == 0, "R9 no underflow", $sformatf("%0d", underflows), "0");
    chk(expQ.size() == 0, "R2 R3 no column lost", $sformatf("%0d left", expQ.size()), "0 left");
    finish();
  end

endmodule